// File: doc/BRIEF.md
# History Buffer Register Recovery

This unit keeps a small working register file that receives results the moment they complete, in whatever order that happens. To make the register state precise again after a fault, it keeps a circular history buffer. At issue time the buffer saves the value the destination register held, and it returns a tag naming that slot. Execution units later report through a completion port addressed by that tag. The report carries the result and a flag saying whether the instruction faulted. The result goes into the register file at once.

The oldest slot is released as soon as its instruction has completed cleanly. If the oldest slot has completed with a fault, the unit first stops accepting issues and waits until every younger outstanding instruction has reported. It then walks the buffer from the youngest slot back to the faulting one. Each cycle it puts one saved value back into the register file. When the walk ends it pulses a done signal and presents the program counter of the faulting instruction as the restart address. The buffer is then empty and tags start again from zero. A read port lets the surrounding logic, or a test, look at any register.

Top module: `hist_recovery_unit`

## Requirements
- R1: After reset the buffer is empty, `iss_ready` is 1, `recov_busy` and `recov_done` are 0, and every register reads 0.
- R2: An issue is accepted in a cycle where `iss_valid` and `iss_ready` are both 1. `iss_tag` in that cycle is the slot given to the instruction. Tags are handed out in sequence 0, 1, 2, … and wrap modulo DEPTH (default 8).
- R3: A completion for an outstanding tag writes `cmp_data` into that slot's destination register. The new value is visible on `peek_data` after the next clock edge, even if older instructions have not completed.
- R4: The oldest slot is released one cycle after it has completed without a fault, which makes room for a new issue.
- R5: `iss_ready` is 0 while DEPTH instructions are outstanding.
- R6: When the oldest slot has completed with a fault, `recov_busy` goes to 1 and `iss_ready` to 0. No register is restored while any younger outstanding instruction has not completed, and completions in that period still write the register file.
- R7: Restoration writes one saved value per cycle, from the youngest slot back to the faulting slot. A register named by several slots therefore ends with the oldest saved value. If all slots have already completed, `recov_busy` stays 1 for N+1 cycles, where N is the number of slots restored.
- R8: At the end of recovery, `recov_done` is 1 for exactly one cycle. `recov_pc` holds the faulting instruction's PC, the buffer is empty, `iss_ready` is 1 and the next tag is 0.
- R9: When an issue and a completion name the same register in the same cycle, the issue saves the value from before the completion write.
- R10: A completion whose tag is not outstanding changes no register.
- R11: A faulting slot that is not the oldest starts no recovery while older slots are still incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | Issue request |
| iss_dest | input | RW | Destination register of the issuing instruction |
| iss_pc | input | PCW | Program counter of the issuing instruction |
| iss_ready | output | 1 | Issue can be accepted this cycle |
| iss_tag | output | TW | Tag given to the instruction issued this cycle |
| cmp_valid | input | 1 | Completion report |
| cmp_tag | input | TW | Tag of the completing instruction |
| cmp_data | input | DW | Result value |
| cmp_exc | input | 1 | Completing instruction faulted |
| peek_addr | input | RW | Register read address |
| peek_data | output | DW | Current value of the addressed register |
| recov_busy | output | 1 | Recovery in progress (draining or restoring) |
| recov_done | output | 1 | One-cycle pulse at the end of recovery |
| recov_pc | output | PCW | Restart address of the last recovery |

## Verification
Some properties are checked on every cycle. Issue is refused when the buffer is full or recovery is under way. Occupancy moves by at most one per cycle outside recovery. Restoration never runs while an outstanding slot is still incomplete. The done pulse lasts one cycle and leaves the buffer empty. Other behaviour only the bench scenarios can show: the register values that come out of a restore with repeated destinations, the capture of the old value when an issue and a completion share a cycle, the exact restart address, and the number of cycles a restore takes.

// File: rtl/hru_pkg.sv
package hru_pkg;
    // Control phases of the recovery unit.
    typedef enum logic [1:0] {
        M_RUN   = 2'd0,  // normal issue / complete / release
        M_DRAIN = 2'd1,  // fault at oldest slot, waiting for younger completions
        M_UNDO  = 2'd2   // writing saved values back, youngest first
    } mode_e;
endpackage

// File: rtl/hru_regfile.sv
module hru_regfile #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [RW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [RW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [RW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    logic [DW-1:0] mem_d [NREG];
    logic [DW-1:0] mem_q [NREG];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // Reads see the registered state, i.e. the value before this cycle's write.
    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/hru_store.sv
module hru_store #(
    parameter int DEPTH = 8,
    parameter int NREG  = 8,
    parameter int DW    = 16,
    parameter int PCW   = 16,
    localparam int RW   = $clog2(NREG),
    localparam int TW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [TW-1:0]    alloc_idx,
    input  logic [RW-1:0]    alloc_dst,
    input  logic [DW-1:0]    alloc_old,
    input  logic [PCW-1:0]   alloc_pc,
    input  logic             fin_en,
    input  logic [TW-1:0]    fin_idx,
    input  logic             fin_exc,
    input  logic             free_en,
    input  logic [TW-1:0]    free_idx,
    input  logic             flush,
    output logic [DEPTH-1:0] valid_o,
    output logic [DEPTH-1:0] done_o,
    output logic [DEPTH-1:0] exc_o,
    output logic [RW-1:0]    dst_o [DEPTH],
    output logic [DW-1:0]    old_o [DEPTH],
    output logic [PCW-1:0]   pc_o  [DEPTH]
);
    typedef struct packed {
        logic           valid;
        logic           done;
        logic           exc;
        logic [RW-1:0]  dst;
        logic [DW-1:0]  old;
        logic [PCW-1:0] pc;
    } slot_t;

    slot_t slot_d [DEPTH];
    slot_t slot_q [DEPTH];

    always_comb begin
        slot_d = slot_q;
        if (free_en) begin
            slot_d[free_idx].valid = 1'b0;
        end
        if (fin_en && slot_q[fin_idx].valid) begin
            slot_d[fin_idx].done = 1'b1;
            slot_d[fin_idx].exc  = fin_exc;
        end
        if (alloc_en) begin
            slot_d[alloc_idx].valid = 1'b1;
            slot_d[alloc_idx].done  = 1'b0;
            slot_d[alloc_idx].exc   = 1'b0;
            slot_d[alloc_idx].dst   = alloc_dst;
            slot_d[alloc_idx].old   = alloc_old;
            slot_d[alloc_idx].pc    = alloc_pc;
        end
        if (flush) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_d[i].valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                slot_q[i] <= '0;
            end
        end else begin
            slot_q <= slot_d;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_out
        assign valid_o[g] = slot_q[g].valid;
        assign done_o[g]  = slot_q[g].done;
        assign exc_o[g]   = slot_q[g].exc;
        assign dst_o[g]   = slot_q[g].dst;
        assign old_o[g]   = slot_q[g].old;
        assign pc_o[g]    = slot_q[g].pc;
    end
endmodule

// File: rtl/hist_recovery_unit.sv
module hist_recovery_unit #(
    parameter int NREG  = 8,
    parameter int DW    = 16,
    parameter int PCW   = 16,
    parameter int DEPTH = 8,     // power of two
    localparam int RW   = $clog2(NREG),
    localparam int TW   = $clog2(DEPTH),
    localparam int CW   = TW + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           iss_valid,
    input  logic [RW-1:0]  iss_dest,
    input  logic [PCW-1:0] iss_pc,
    output logic           iss_ready,
    output logic [TW-1:0]  iss_tag,
    input  logic           cmp_valid,
    input  logic [TW-1:0]  cmp_tag,
    input  logic [DW-1:0]  cmp_data,
    input  logic           cmp_exc,
    input  logic [RW-1:0]  peek_addr,
    output logic [DW-1:0]  peek_data,
    output logic           recov_busy,
    output logic           recov_done,
    output logic [PCW-1:0] recov_pc
);
    import hru_pkg::*;

    typedef struct packed {
        mode_e          mode;
        logic [TW-1:0]  head;
        logic [TW-1:0]  tail;
        logic [TW-1:0]  rptr;
        logic [CW-1:0]  cnt;
        logic           done_p;
        logic [PCW-1:0] fpc;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [DEPTH-1:0] s_valid, s_done, s_exc;
    logic [RW-1:0]    s_dst [DEPTH];
    logic [DW-1:0]    s_old [DEPTH];
    logic [PCW-1:0]   s_pc  [DEPTH];

    logic          iss_fire, cmp_fire, release_head, head_fault, flush;
    logic          rf_we;
    logic [RW-1:0] rf_waddr;
    logic [DW-1:0] rf_wdata;
    logic [DW-1:0] cur_old;

    // Probe points for the bound checker.
    logic [CW-1:0] occ;
    logic          undoing;
    logic          drained;

    assign drained = &(s_done | ~s_valid);

    always_comb begin
        ctl_d        = ctl_q;
        ctl_d.done_p = 1'b0;

        iss_ready    = (ctl_q.mode == M_RUN) && (ctl_q.cnt != CW'(DEPTH));
        iss_fire     = iss_valid && iss_ready;
        cmp_fire     = cmp_valid && s_valid[cmp_tag] && (ctl_q.mode != M_UNDO);
        head_fault   = s_valid[ctl_q.head] && s_done[ctl_q.head] && s_exc[ctl_q.head];
        release_head = 1'b0;
        flush        = 1'b0;

        rf_we    = cmp_fire;
        rf_waddr = s_dst[cmp_tag];
        rf_wdata = cmp_data;

        unique case (ctl_q.mode)
            M_RUN: begin
                if (head_fault) begin
                    ctl_d.mode = M_DRAIN;
                end else if (s_valid[ctl_q.head] && s_done[ctl_q.head]) begin
                    release_head = 1'b1;
                    ctl_d.head   = ctl_q.head + TW'(1);
                end
                if (iss_fire) begin
                    ctl_d.tail = ctl_q.tail + TW'(1);
                end
                ctl_d.cnt = ctl_q.cnt + CW'(iss_fire) - CW'(release_head);
            end
            M_DRAIN: begin
                if (drained) begin
                    ctl_d.mode = M_UNDO;
                    ctl_d.rptr = ctl_q.tail - TW'(1);
                end
            end
            M_UNDO: begin
                rf_we    = 1'b1;
                rf_waddr = s_dst[ctl_q.rptr];
                rf_wdata = s_old[ctl_q.rptr];
                if (ctl_q.rptr == ctl_q.head) begin
                    flush        = 1'b1;
                    ctl_d.mode   = M_RUN;
                    ctl_d.done_p = 1'b1;
                    ctl_d.fpc    = s_pc[ctl_q.head];
                    ctl_d.head   = '0;
                    ctl_d.tail   = '0;
                    ctl_d.cnt    = '0;
                end else begin
                    ctl_d.rptr = ctl_q.rptr - TW'(1);
                end
            end
            default: ctl_d.mode = M_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    hru_regfile #(.NREG(NREG), .DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (rf_wdata),
        .raddr_a (iss_dest),
        .rdata_a (cur_old),
        .raddr_b (peek_addr),
        .rdata_b (peek_data)
    );

    hru_store #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW), .PCW(PCW)) u_hb (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (iss_fire),
        .alloc_idx (ctl_q.tail),
        .alloc_dst (iss_dest),
        .alloc_old (cur_old),
        .alloc_pc  (iss_pc),
        .fin_en    (cmp_fire),
        .fin_idx   (cmp_tag),
        .fin_exc   (cmp_exc),
        .free_en   (release_head),
        .free_idx  (ctl_q.head),
        .flush     (flush),
        .valid_o   (s_valid),
        .done_o    (s_done),
        .exc_o     (s_exc),
        .dst_o     (s_dst),
        .old_o     (s_old),
        .pc_o      (s_pc)
    );

    assign iss_tag    = ctl_q.tail;
    assign recov_busy = (ctl_q.mode != M_RUN);
    assign recov_done = ctl_q.done_p;
    assign recov_pc   = ctl_q.fpc;
    assign occ        = ctl_q.cnt;
    assign undoing    = (ctl_q.mode == M_UNDO);
endmodule

// File: rtl/hru_checker.sv
module hru_checker #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          iss_ready,
    input logic          recov_busy,
    input logic          recov_done,
    input logic [CW-1:0] occ,
    input logic          undoing,
    input logic          drained
);
    a_r5_full_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !iss_ready);

    a_r6_busy_blocks_issue: assert property (@(posedge clk) disable iff (!rst_n)
        recov_busy |-> !iss_ready);

    a_r2_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    a_r4_occ_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!recov_busy && !$past(recov_busy) && !recov_done)
        |-> (occ == $past(occ) || occ == $past(occ) + CW'(1) || occ + CW'(1) == $past(occ)));

    a_r7_restore_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        undoing |-> drained);

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        recov_done |=> !recov_done);

    a_r8_empty_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        recov_done |-> (occ == '0 && !recov_busy));

    a_r6_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(recov_busy) |-> recov_done);
endmodule

bind hist_recovery_unit hru_checker #(.DEPTH(DEPTH), .CW(CW)) u_hru_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_ready  (iss_ready),
    .recov_busy (recov_busy),
    .recov_done (recov_done),
    .occ        (occ),
    .undoing    (undoing),
    .drained    (drained)
);

// File: tb/hist_recovery_unit_bench.sv
`timescale 1ns/1ps
module hist_recovery_unit_bench;
    localparam int NREG  = 8;
    localparam int DW    = 16;
    localparam int PCW   = 16;
    localparam int DEPTH = 8;
    localparam int RW    = $clog2(NREG);
    localparam int TW    = $clog2(DEPTH);

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           iss_valid = 1'b0;
    logic [RW-1:0]  iss_dest = '0;
    logic [PCW-1:0] iss_pc = '0;
    logic           iss_ready;
    logic [TW-1:0]  iss_tag;
    logic           cmp_valid = 1'b0;
    logic [TW-1:0]  cmp_tag = '0;
    logic [DW-1:0]  cmp_data = '0;
    logic           cmp_exc = 1'b0;
    logic [RW-1:0]  peek_addr = '0;
    logic [DW-1:0]  peek_data;
    logic           recov_busy;
    logic           recov_done;
    logic [PCW-1:0] recov_pc;

    hist_recovery_unit #(.NREG(NREG), .DW(DW), .PCW(PCW), .DEPTH(DEPTH)) u_hist_recovery_unit (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_dest(iss_dest), .iss_pc(iss_pc),
        .iss_ready(iss_ready), .iss_tag(iss_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data), .cmp_exc(cmp_exc),
        .peek_addr(peek_addr), .peek_data(peek_data),
        .recov_busy(recov_busy), .recov_done(recov_done), .recov_pc(recov_pc)
    );

    always #5 clk = ~clk;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    bit reported = 0;

    // Reference model: register values and per-tag slot contents.
    int mrf  [NREG];
    int m_rd [DEPTH];
    int m_old[DEPTH];
    int m_pc [DEPTH];

    task automatic report;
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than 100000", cyc);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input int rd, input int pc, output int tag);
        @(negedge clk);
        chk(iss_ready === 1'b1, "R2 ready before issue", int'(iss_ready), 1);
        iss_valid = 1'b1;
        iss_dest  = RW'(rd);
        iss_pc    = PCW'(pc);
        tag       = int'(iss_tag);
        m_rd[tag]  = rd;
        m_old[tag] = mrf[rd];
        m_pc[tag]  = pc;
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
    endtask

    task automatic complete(input int tag, input int data, input bit exc);
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_tag   = TW'(tag);
        cmp_data  = DW'(data);
        cmp_exc   = exc;
        mrf[m_rd[tag]] = data;
        @(posedge clk);
        #1;
        cmp_valid = 1'b0;
        cmp_exc   = 1'b0;
    endtask

    // Issue and completion in the same cycle; the saved old value is pre-write.
    task automatic issue_and_complete(input int rd, input int pc, input int ctag,
                                      input int data, output int tag);
        @(negedge clk);
        iss_valid = 1'b1;
        iss_dest  = RW'(rd);
        iss_pc    = PCW'(pc);
        tag       = int'(iss_tag);
        m_rd[tag]  = rd;
        m_old[tag] = mrf[rd];
        m_pc[tag]  = pc;
        cmp_valid = 1'b1;
        cmp_tag   = TW'(ctag);
        cmp_data  = DW'(data);
        cmp_exc   = 1'b0;
        mrf[m_rd[ctag]] = data;
        @(posedge clk);
        #1;
        iss_valid = 1'b0;
        cmp_valid = 1'b0;
    endtask

    task automatic peek(input int r, output int v);
        peek_addr = RW'(r);
        #0.5;
        v = int'(peek_data);
    endtask

    task automatic check_rf(input string req);
        @(negedge clk);
        for (int r = 0; r < NREG; r++) begin
            int v;
            peek(r, v);
            chk(v == mrf[r], req, v, mrf[r]);
        end
    endtask

    task automatic await_recovery(input int exp_cycles, input bit chk_cycles,
                                  input int exp_pc, input string req);
        int guard = 0;
        int cnt = 0;
        @(negedge clk);
        while (!recov_busy && guard < 60) begin
            guard++;
            @(negedge clk);
        end
        while (recov_busy && guard < 120) begin
            cnt++;
            guard++;
            chk(iss_ready === 1'b0, "R6 no issue during recovery", int'(iss_ready), 0);
            @(negedge clk);
        end
        chk(recov_done === 1'b1, "R8 done pulse", int'(recov_done), 1);
        chk(int'(recov_pc) == exp_pc, "R8 restart pc", int'(recov_pc), exp_pc);
        if (chk_cycles) begin
            chk(cnt == exp_cycles, {req, " R7 restore cycle count"}, cnt, exp_cycles);
        end
        @(negedge clk);
        chk(recov_done === 1'b0, "R8 done lasts one cycle", int'(recov_done), 0);
        chk(iss_ready === 1'b1 && int'(iss_tag) == 0, "R8 empty, tags restart",
            int'(iss_tag), 0);
    endtask

    initial begin
        int tg[DEPTH];
        int t0;
        int v;
        for (int r = 0; r < NREG; r++) mrf[r] = 0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk(iss_ready === 1'b1, "R1 ready after reset", int'(iss_ready), 1);
        chk(recov_busy === 1'b0, "R1 busy after reset", int'(recov_busy), 0);
        chk(recov_done === 1'b0, "R1 done after reset", int'(recov_done), 0);
        chk(int'(iss_tag) == 0, "R1 first tag", int'(iss_tag), 0);
        check_rf("R1 register reset value");

        // R2/R3: load every register, tags in sequence
        for (int r = 0; r < NREG; r++) begin
            issue(r, 16'h0100 + r * 4, t0);
            chk(t0 == r % DEPTH, "R2 tag sequence", t0, r % DEPTH);
            complete(t0, 16'h0100 + r, 1'b0);
        end
        check_rf("R3 completion write");

        // R5: fill the buffer, tags wrap
        for (int i = 0; i < DEPTH; i++) begin
            issue(i, 16'h0200 + i * 4, tg[i]);
            chk(tg[i] == i, "R2 tag wraps", tg[i], i);
        end
        @(negedge clk);
        chk(iss_ready === 1'b0, "R5 full blocks issue", int'(iss_ready), 0);
        // R3: youngest completes before older ones
        complete(tg[DEPTH-1], 16'h0A07, 1'b0);
        peek(DEPTH - 1, v);
        chk(v == 16'h0A07, "R3 out-of-order write visible", v, 16'h0A07);
        chk(iss_ready === 1'b0, "R4 young completion frees nothing", int'(iss_ready), 0);
        // R4: release of the oldest slot
        complete(tg[0], 16'h0A00, 1'b0);
        @(negedge clk);
        chk(iss_ready === 1'b0, "R4 release not yet taken", int'(iss_ready), 0);
        tick();
        @(negedge clk);
        chk(iss_ready === 1'b1, "R4 oldest released", int'(iss_ready), 1);
        for (int i = 1; i < DEPTH - 1; i++) complete(tg[i], 16'h0A00 + i, 1'b0);
        repeat (DEPTH + 2) tick();
        check_rf("R3 all writes kept");

        // R9: issue and completion on the same register in one cycle
        issue(2, 16'h0300, tg[0]);
        issue_and_complete(2, 16'h0304, tg[0], 16'hBEEF, tg[1]);
        peek(2, v);
        chk(v == 16'hBEEF, "R9 completion written", v, 16'hBEEF);
        complete(tg[1], 16'h5555, 1'b1);
        mrf[m_rd[tg[1]]] = m_old[tg[1]];
        await_recovery(2, 1'b1, 16'h0304, "R9");
        check_rf("R9 old value captured before write");

        // R6/R7/R11: sweep of buffer fill, fault position and completion order
        for (int t = 0; t < 6; t++) begin
            int n;
            int e;
            n = 3 + t;
            e = (t % 2 == 1) ? 0 : t / 2;
            for (int i = 0; i < n; i++) begin
                issue((i * 3 + t) % 4, 16'h0400 + t * 64 + i * 4, tg[i]);
            end
            if (t % 2 == 0) begin
                for (int i = n - 1; i >= 0; i--) begin
                    complete(tg[i], 16'h1000 * (t + 1) + i, i == e);
                    peek(m_rd[tg[i]], v);
                    chk(v == mrf[m_rd[tg[i]]], "R3 write at completion", v, mrf[m_rd[tg[i]]]);
                    if (i == e && e > 0) begin
                        tick();
                        tick();
                        @(negedge clk);
                        chk(recov_busy === 1'b0, "R11 younger fault waits", int'(recov_busy), 0);
                    end
                end
                for (int i = n - 1; i >= e; i--) mrf[m_rd[tg[i]]] = m_old[tg[i]];
                await_recovery(n - e + 1, 1'b1, m_pc[tg[e]], "R7");
            end else begin
                complete(tg[0], 16'h1000 * (t + 1), 1'b1);
                repeat (4) tick();
                @(negedge clk);
                chk(recov_busy === 1'b1, "R6 busy while draining", int'(recov_busy), 1);
                chk(iss_ready === 1'b0, "R6 issue stopped", int'(iss_ready), 0);
                chk(recov_done === 1'b0, "R6 no early done", int'(recov_done), 0);
                peek(m_rd[tg[0]], v);
                chk(v == mrf[m_rd[tg[0]]], "R6 no restore before drain", v, mrf[m_rd[tg[0]]]);
                for (int i = 1; i < n; i++) complete(tg[i], 16'h1000 * (t + 1) + i, 1'b0);
                for (int i = n - 1; i >= 0; i--) mrf[m_rd[tg[i]]] = m_old[tg[i]];
                await_recovery(0, 1'b0, m_pc[tg[0]], "R6");
            end
            check_rf("R7 restored registers");
        end

        // R10: completion for a tag that is not outstanding
        @(negedge clk);
        cmp_valid = 1'b1;
        cmp_tag   = TW'(3);
        cmp_data  = 16'hDEAD;
        cmp_exc   = 1'b0;
        tick();
        cmp_valid = 1'b0;
        tick();
        check_rf("R10 stale completion ignored");
        chk(recov_busy === 1'b0, "R10 no recovery from stale tag", int'(recov_busy), 0);

        report();
    end
endmodule